// File: doc/BRIEF.md
# Four-Lane Alignment Status Monitor

This block watches the four decoded byte lanes of one receive channel and decides whether the lanes are aligned to each other. Each lane delivers one decoded byte per clock, together with a flag that marks the byte as a control character and a flag that says the lane holds byte synchronisation. The monitor looks for the alignment control character on every lane. It groups the arrivals into columns and records, for each lane, how many clocks after the first arrival its own alignment character came. It then judges each column.

A column can be bad for three separate reasons. A lane may never show the character within the window. The spread between the earliest and latest lane may exceed the tolerated skew. The per-lane offsets may differ from those of the previous column that was complete and within limits. A run of good columns declares alignment. A run of bad columns, or the loss of byte sync on any lane, withdraws it. The four byte-sync flags are also registered and brought out for a status register view. The monitor neither moves data nor decodes it.

Top module: `lane_align_monitor`

## Requirements
- R1: A lane's byte counts as the alignment character only when its control flag is 1 and its byte equals 0x7C. The value 0x7C with the flag at 0, or any other control byte, has no effect on columns or on `aligned_o`.
- R2: The first alignment character seen while no column is open opens a column, and that cycle is offset 0. The column closes as good or bad in the cycle its fourth lane is seen. If some lane has still not been seen by offset WINDOW-1 (default 8 clocks, offsets 0 to 7), the column closes as bad.
- R3: A complete column whose largest lane offset exceeds MAX_SKEW (default 4) is bad. A spread of exactly MAX_SKEW is allowed. A bad column of this kind, or one with a missing lane, leaves no reference for the next consistency check.
- R4: A complete column within the skew limit is bad when its four offsets differ from those of the previous complete, in-limit column. Either way, its own offsets become the new reference.
- R5: `aligned_o` rises on the clock edge that closes the ACQ_COLS-th consecutive good column (default 4), and not earlier.
- R6: Once aligned, `aligned_o` falls on the edge that closes the LOSS_COLS-th consecutive bad column (default 4). Any good column in between restarts that count.
- R7: While any lane's sync flag is 0, the next edge clears `aligned_o`. The same edge abandons any open column, clears both run counts and drops the offset reference. Alignment characters are ignored during those cycles.
- R8: `lane_sync_status_o` bit i equals lane i's sync flag one clock earlier.
- R9: During and just after reset, `aligned_o` is 0 and `lane_sync_status_o` is 4'b0000.
- R10: Within an open column, only the first alignment character on a lane sets that lane's offset. Later ones on the same lane are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_byte_i | input | 32 | Decoded bytes; lane i at bits [8i+7:8i] |
| lane_ctrl_i | input | 4 | Control-character flag per lane |
| lane_sync_i | input | 4 | Byte-sync flag per lane |
| aligned_o | output | 1 | Registered lane-alignment status |
| lane_sync_status_o | output | 4 | Registered per-lane byte-sync view |

## Verification
The bench first sends control bytes that merely look like the alignment character. A decoder with a loose match would then declare alignment from noise. It repeats an alignment character on one lane inside an open column, so a design that lets the later arrival overwrite the offset would count a fourth bad column and drop alignment. The skew is driven to exactly the limit and then one clock past it, which catches an off-by-one in the spread test. Mismatched columns are interleaved with a single good one, which catches a loss counter that fails to restart. A one-cycle sync loss on a single lane must clear alignment at once and wipe the reference. After it, the bench feeds a constrained-random column stream, and a spec model checks that stream every cycle.

// File: rtl/lam_pkg.sv
package lam_pkg;
    localparam int         LANES      = 4;
    localparam logic [7:0] ALIGN_CODE = 8'h7C;

    function automatic logic is_align_char(input logic [7:0] b, input logic k);
        return k && (b == ALIGN_CODE);
    endfunction
endpackage

// File: rtl/lam_lane_slot.sv
// Per-lane arrival record for the column that is currently open.
module lam_lane_slot #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic          col_open,
    input  logic          keep,
    input  logic [CW-1:0] cur_cnt,
    output logic          seen_nx,
    output logic [CW-1:0] off_nx
);
    typedef struct packed {
        logic          seen;
        logic [CW-1:0] off;
    } slot_t;

    slot_t st_q, st_d;
    logic  seen_prev;
    logic  first_hit;

    always_comb begin
        seen_prev = col_open & st_q.seen;
        first_hit = hit & ~seen_prev;
        seen_nx   = seen_prev | hit;
        off_nx    = first_hit ? cur_cnt : st_q.off;
        st_d.seen = keep & seen_nx;
        st_d.off  = keep ? off_nx : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: a lane already recorded keeps its offset while the column stays open
    p_first_hit_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (col_open && st_q.seen && keep) |=> $stable(st_q.off));
endmodule

// File: rtl/lam_col_judge.sv
// Judges a closing column: missing lane, skew spread, consistency with reference.
module lam_col_judge #(
    parameter int LANES    = 4,
    parameter int CW       = 3,
    parameter int MAX_SKEW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                close_full,
    input  logic                close_miss,
    input  logic [LANES*CW-1:0] offs,
    output logic                verdict_valid,
    output logic                verdict_good
);
    typedef struct packed {
        logic                valid;
        logic [LANES*CW-1:0] offs;
    } ref_t;

    ref_t          ref_q, ref_d;
    logic [CW-1:0] spread;
    logic          too_wide;
    logic          mismatch;

    always_comb begin
        spread = '0;
        for (int i = 0; i < LANES; i++) begin
            if (offs[i*CW +: CW] > spread) spread = offs[i*CW +: CW];
        end
        too_wide      = int'(spread) > MAX_SKEW;
        mismatch      = ref_q.valid && (offs != ref_q.offs);
        verdict_valid = close_full | close_miss;
        verdict_good  = close_full & ~too_wide & ~mismatch;

        ref_d = ref_q;
        if (flush || close_miss || (close_full && too_wide)) begin
            ref_d.valid = 1'b0;
        end else if (close_full) begin
            ref_d.valid = 1'b1;
            ref_d.offs  = offs;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= '0;
        else        ref_q <= ref_d;
    end

    // R4: a good complete column always leaves a valid reference behind
    p_ref_after_good_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_good && !flush) |=> ref_q.valid);
endmodule

// File: rtl/lam_run_tracker.sv
// Counts consecutive good / bad columns and holds the alignment state.
module lam_run_tracker #(
    parameter int ACQ_COLS  = 4,
    parameter int LOSS_COLS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic v_valid,
    input  logic v_good,
    output logic aligned
);
    localparam int RMAX = (ACQ_COLS > LOSS_COLS) ? ACQ_COLS : LOSS_COLS;
    localparam int RW   = $clog2(RMAX + 1);

    typedef struct packed {
        logic [RW-1:0] good;
        logic [RW-1:0] bad;
        logic          al;
    } run_t;

    run_t          st_q, st_d;
    logic [RW-1:0] good_inc, bad_inc;

    always_comb begin
        good_inc = (st_q.good >= RW'(ACQ_COLS))  ? st_q.good : st_q.good + RW'(1);
        bad_inc  = (st_q.bad  >= RW'(LOSS_COLS)) ? st_q.bad  : st_q.bad  + RW'(1);
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else if (v_valid) begin
            if (v_good) begin
                st_d.good = good_inc;
                st_d.bad  = '0;
                if (good_inc >= RW'(ACQ_COLS)) st_d.al = 1'b1;
            end else begin
                st_d.bad  = bad_inc;
                st_d.good = '0;
                if (bad_inc >= RW'(LOSS_COLS)) st_d.al = 1'b0;
            end
        end
        aligned = st_q.al;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_rise_after_good_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.al) |-> $past(v_valid && v_good && !flush));
    p_fall_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.al) |-> $past(flush || (v_valid && !v_good)));
    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !st_q.al);
endmodule

// File: rtl/lane_align_monitor.sv
module lane_align_monitor #(
    parameter int WINDOW    = 8,
    parameter int MAX_SKEW  = 4,
    parameter int ACQ_COLS  = 4,
    parameter int LOSS_COLS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] lane_byte_i,
    input  logic [3:0]  lane_ctrl_i,
    input  logic [3:0]  lane_sync_i,
    output logic        aligned_o,
    output logic [3:0]  lane_sync_status_o
);
    import lam_pkg::*;

    localparam int CW = $clog2(WINDOW);

    typedef struct packed {
        logic          open;
        logic [CW-1:0] cnt;
        logic [3:0]    sync;
    } ctl_t;

    ctl_t                ctl_q, ctl_d;
    logic                sync_all;
    logic [LANES-1:0]    hit;
    logic [LANES-1:0]    seen_nx;
    logic [LANES*CW-1:0] off_nx;
    logic [CW-1:0]       cur_cnt;
    logic                active, close_full, close_miss, keep;
    logic                v_valid, v_good;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign hit[i] = sync_all && is_align_char(lane_byte_i[8*i +: 8], lane_ctrl_i[i]);
        lam_lane_slot #(.CW(CW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (hit[i]),
            .col_open (ctl_q.open),
            .keep     (keep),
            .cur_cnt  (cur_cnt),
            .seen_nx  (seen_nx[i]),
            .off_nx   (off_nx[i*CW +: CW])
        );
    end

    always_comb begin
        sync_all   = &lane_sync_i;
        cur_cnt    = ctl_q.open ? ctl_q.cnt + CW'(1) : '0;
        active     = sync_all && (ctl_q.open || (|hit));
        close_full = active && (&seen_nx);
        close_miss = active && !(&seen_nx) && (cur_cnt == CW'(WINDOW - 1));
        keep       = active && !close_full && !close_miss;

        ctl_d      = ctl_q;
        ctl_d.open = keep;
        ctl_d.cnt  = keep ? cur_cnt : '0;
        ctl_d.sync = lane_sync_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    lam_col_judge #(.LANES(LANES), .CW(CW), .MAX_SKEW(MAX_SKEW)) u_judge (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (!sync_all),
        .close_full    (close_full),
        .close_miss    (close_miss),
        .offs          (off_nx),
        .verdict_valid (v_valid),
        .verdict_good  (v_good)
    );

    lam_run_tracker #(.ACQ_COLS(ACQ_COLS), .LOSS_COLS(LOSS_COLS)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (!sync_all),
        .v_valid (v_valid),
        .v_good  (v_good),
        .aligned (aligned_o)
    );

    assign lane_sync_status_o = ctl_q.sync;

    // R2: an open column never outlives its window
    p_window_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.open |-> (ctl_q.cnt < CW'(WINDOW - 1)));
    // R8: status view follows the sync inputs one clock later
    p_sync_view_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lane_sync_status_o == $past(lane_sync_i)));
    // R7: with any lane unsynchronised no column survives the edge
    p_no_column_unsynced_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(&lane_sync_i) |=> !ctl_q.open);
endmodule

// File: tb/tb_lane_align_monitor.sv
`timescale 1ns/1ps
module tb_lane_align_monitor;
    localparam int W    = 8;
    localparam int MS   = 4;
    localparam int ACQ  = 4;
    localparam int LOSS = 4;
    localparam int COLLEN = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] byt = '0;
    logic [3:0]  kk = '0;
    logic [3:0]  sy = '0;
    logic        aligned_o;
    logic [3:0]  lane_sync_status_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    lane_align_monitor #(.WINDOW(W), .MAX_SKEW(MS), .ACQ_COLS(ACQ), .LOSS_COLS(LOSS)) dut (
        .clk(clk), .rst_n(rst_n), .lane_byte_i(byt), .lane_ctrl_i(kk),
        .lane_sync_i(sy), .aligned_o(aligned_o), .lane_sync_status_o(lane_sync_status_o)
    );

    // spec model state
    bit         m_open;
    int         m_cnt;
    bit         m_seen[4];
    int         m_off[4];
    int         m_ref[4];
    bit         m_refv;
    int         m_good, m_bad;
    bit         m_al;
    logic [3:0] m_sync;

    function automatic void m_verdict(bit good);
        if (good) begin
            m_bad = 0;
            if (m_good < ACQ) m_good++;
            if (m_good >= ACQ) m_al = 1;
        end else begin
            m_good = 0;
            if (m_bad < LOSS) m_bad++;
            if (m_bad >= LOSS) m_al = 0;
        end
    endfunction

    function automatic void model_step();
        bit hit[4];
        bit any = 0;
        bit all_seen = 1;
        int cur;
        int spread = 0;
        bit mism = 0;
        for (int i = 0; i < 4; i++) begin
            hit[i] = (&sy) && kk[i] && (byt[8*i +: 8] == 8'h7C);
            any |= hit[i];
        end
        m_sync = sy;
        if (!(&sy)) begin
            m_open = 0; m_refv = 0; m_good = 0; m_bad = 0; m_al = 0;
            return;
        end
        if (!(m_open || any)) return;
        cur = m_open ? m_cnt + 1 : 0;
        for (int i = 0; i < 4; i++) begin
            if (!m_open) m_seen[i] = 0;
            if (hit[i] && !m_seen[i]) begin m_seen[i] = 1; m_off[i] = cur; end
            all_seen &= m_seen[i];
        end
        if (all_seen) begin
            m_open = 0;
            for (int i = 0; i < 4; i++) if (m_off[i] > spread) spread = m_off[i];
            if (spread > MS) begin
                m_refv = 0; m_verdict(0);
            end else begin
                for (int i = 0; i < 4; i++) if (m_refv && m_off[i] != m_ref[i]) mism = 1;
                for (int i = 0; i < 4; i++) m_ref[i] = m_off[i];
                m_refv = 1;
                m_verdict(!mism);
            end
        end else if (cur == W - 1) begin
            m_open = 0; m_refv = 0; m_verdict(0);
        end else begin
            m_open = 1; m_cnt = cur;
        end
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic step(string tag);
        @(posedge clk);
        if (rst_n) model_step();
        @(negedge clk);
        check({tag, " aligned"}, {3'b0, aligned_o}, {3'b0, m_al});
        check({tag, " sync view R8"}, lane_sync_status_o, m_sync);
    endtask

    task automatic idle_lanes();
        for (int i = 0; i < 4; i++) begin
            byt[8*i +: 8] = 8'hBC;
            kk[i] = 1'b1;
        end
    endtask

    // send one column: lane i gets the alignment character at cycle o[i] if mask[i]
    task automatic send_column(string tag, int o0, int o1, int o2, int o3,
                               logic [3:0] mask, int dup_t = -1);
        int o[4];
        o[0] = o0; o[1] = o1; o[2] = o2; o[3] = o3;
        for (int t = 0; t < COLLEN; t++) begin
            idle_lanes();
            for (int i = 0; i < 4; i++)
                if (mask[i] && t == o[i]) byt[8*i +: 8] = 8'h7C;
            if (t == dup_t) byt[7:0] = 8'h7C;
            step(tag);
        end
    endtask

    task automatic expect_al(string tag, logic exp);
        check(tag, {3'b0, aligned_o}, {3'b0, exp});
    endtask

    initial begin
        #(20.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_open = 0; m_cnt = 0; m_refv = 0; m_good = 0; m_bad = 0; m_al = 0; m_sync = '0;
        for (int i = 0; i < 4; i++) begin m_seen[i] = 0; m_off[i] = 0; m_ref[i] = 0; end
        idle_lanes();
        sy = 4'hF;
        repeat (3) @(negedge clk);
        // R9: reset state
        expect_al("R9 reset aligned", 1'b0);
        check("R9 reset sync view", lane_sync_status_o, 4'h0);
        rst_n = 1'b1;
        step("R9 first cycle");

        // R1: look-alike bytes must not form columns
        for (int c = 0; c < 5; c++) begin
            for (int t = 0; t < COLLEN; t++) begin
                for (int i = 0; i < 4; i++) begin
                    byt[8*i +: 8] = (t == i) ? ((c % 2 == 0) ? 8'h7C : 8'h7D) : 8'hBC;
                    kk[i] = (t == i) ? (c % 2 == 1) : 1'b1;
                end
                step("R1 look-alike");
            end
        end
        expect_al("R1 no alignment from look-alikes", 1'b0);

        // R5: acquisition after exactly four good columns
        for (int c = 0; c < 3; c++) send_column("R5 acquire", 0, 1, 2, 3, 4'hF);
        expect_al("R5 not yet after three", 1'b0);
        send_column("R5 acquire", 0, 1, 2, 3, 4'hF);
        expect_al("R5 aligned after four", 1'b1);

        // R4 + R10: three inconsistent columns, then a consistent one with a repeated hit
        send_column("R4 mismatch", 0, 1, 2, 4, 4'hF);
        send_column("R4 mismatch", 0, 1, 2, 3, 4'hF);
        send_column("R4 mismatch", 0, 1, 2, 4, 4'hF);
        expect_al("R6 held after three bad", 1'b1);
        send_column("R10 repeat hit", 0, 1, 2, 4, 4'hF, 3);
        expect_al("R10 repeated hit ignored", 1'b1);
        // R6: good column restarted the count
        send_column("R6 bad", 0, 1, 2, 3, 4'hF);
        send_column("R6 bad", 0, 1, 2, 4, 4'hF);
        send_column("R6 bad", 0, 1, 2, 3, 4'hF);
        expect_al("R6 count restarted by good column", 1'b1);
        send_column("R4 bad", 0, 1, 2, 4, 4'hF);
        expect_al("R4 lost after four inconsistent", 1'b0);

        // R7: re-acquire, then one-cycle sync drop on lane 2
        for (int c = 0; c < 4; c++) send_column("R7 reacquire", 0, 1, 2, 4, 4'hF);
        expect_al("R7 aligned before drop", 1'b1);
        idle_lanes();
        sy = 4'b1011;
        step("R7 drop");
        expect_al("R7 immediate loss", 1'b0);
        check("R8 status shows lane 2 down", lane_sync_status_o, 4'b1011);
        sy = 4'hF;
        step("R7 restore");
        check("R8 status restored", lane_sync_status_o, 4'hF);

        // R3 boundary: spread of exactly MAX_SKEW is good; reference was flushed
        for (int c = 0; c < 3; c++) send_column("R3 edge", 0, 4, 0, 0, 4'hF);
        expect_al("R7 counts cleared by drop", 1'b0);
        send_column("R3 edge", 0, 4, 0, 0, 4'hF);
        expect_al("R3 spread at limit accepted", 1'b1);
        for (int c = 0; c < 3; c++) send_column("R3 wide", 0, 5, 0, 0, 4'hF);
        expect_al("R3 held after three wide", 1'b1);
        send_column("R3 wide", 0, 5, 0, 0, 4'hF);
        expect_al("R3 lost after four wide", 1'b0);

        // R2: missing lane
        for (int c = 0; c < 4; c++) send_column("R2 reacquire", 0, 0, 0, 0, 4'hF);
        expect_al("R2 aligned", 1'b1);
        for (int c = 0; c < 3; c++) send_column("R2 missing", 0, 0, 0, 0, 4'b0111);
        expect_al("R2 held after three missing", 1'b1);
        send_column("R2 missing", 0, 0, 0, 0, 4'b0111);
        expect_al("R2 lost after four missing", 1'b0);

        // constrained random columns checked every cycle against the model
        for (int c = 0; c < 220; c++) begin
            int pat = $urandom_range(0, 9);
            int o[4];
            logic [3:0] mask = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15)) : 4'hF;
            for (int i = 0; i < 4; i++)
                o[i] = (pat < 7) ? ((i == 1) ? 2 : (i == 3) ? 1 : 0) : $urandom_range(0, 6);
            o[$urandom_range(0, 3)] = 0;
            for (int t = 0; t < COLLEN; t++) begin
                for (int i = 0; i < 4; i++) begin
                    byt[8*i +: 8] = 8'($urandom_range(0, 255));
                    kk[i] = ($urandom_range(0, 3) == 0);
                    if (byt[8*i +: 8] == 8'h7C) kk[i] = 1'b0;
                    if (mask[i] && t == o[i]) begin byt[8*i +: 8] = 8'h7C; kk[i] = 1'b1; end
                end
                sy = ($urandom_range(0, 299) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
                step("R1-model random");
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule